// File: doc/BRIEF.md
# Two-Channel Interrupt Pending Collector

This block gathers interrupt requests for a serial controller with two channels, A and B. Each channel has three request sources: receive, transmit, and external/status. Receive requests follow one of four programmable modes, and a set of receive error events counts as a special condition. Transmit requests latch when the transmit buffer empties. External/status requests latch on a change in either direction of any status input that has its mask bit set. All six latched bits appear in one byte-wide pending register.

Each latched bit stays set until its own clear strobe arrives. A master enable gates the interrupt output. A fixed-priority encoder reports the most urgent pending source. While a status request is latched, the status snapshot is frozen. A change that happens during that time is reported after the request is cleared, so it is not lost.

Each channel index selects one channel: index 0 is channel A and index 1 is channel B. Strobes are one clock wide. Status inputs are levels that are already synchronous to `clk`.

Top module: `dual_chan_irq`

## Requirements
- R1: After reset, `pend` is 0x00, `irq` is 0 and `irq_id` is 7. The first clock after reset loads the snapshot from `st_in` and raises no status request.
- R2: The `pend` bit positions are as follows. Bits 7:6 always read as zero. Bit 5 is A receive, bit 4 is A transmit and bit 3 is A status. Bit 2 is B receive, bit 1 is B transmit and bit 0 is B status.
- R3: With `rx_mode` 2'b00, no receive request is latched. With 2'b10, every `rx_char` strobe latches a receive request.
- R4: With `rx_mode` 2'b01, only the first `rx_char` after reset, or after a `cmd_rearm_rx` strobe, latches a receive request. Special conditions always latch one.
- R5: With `rx_mode` 2'b11, an `rx_char` strobe alone latches nothing. Overrun, framing error and end of frame latch a receive request. A parity error latches one only when `par_sc_en` is 1.
- R6: A `tx_empty` strobe latches a transmit request only when `tx_ie` is 1. `cmd_rst_tx` clears that request.
- R7: With `st_ie` at 1, a rising or a falling change on a status input whose `st_mask` bit is 1 latches a status request. Changes on masked-off inputs latch nothing. `cmd_rst_st` clears the request.
- R8: While a status request is latched, `st_snap` holds its value. A change during that time latches a new request on the clock after the clearing `cmd_rst_st`.
- R9: `irq` is 1 exactly when `master_ie` is 1 and some `pend` bit is set. With `master_ie` at 0, requests are still latched into `pend`.
- R10: `irq_id` gives the highest set source in the order A receive (0), A transmit (1), A status (2), B receive (3), B transmit (4), B status (5). It is 7 when nothing is pending.
- R11: A set and a clear on the same source in the same cycle leave the bit set. `cmd_ack_rx` alone clears the receive request.
- R12: A request latched by a strobe at clock edge k appears in `pend` right after edge k, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_mode | input | 2x2 | Receive request mode for each channel (00 off, 01 first char, 10 every char, 11 special only) |
| par_sc_en | input | 2 | Parity error counts as a special condition |
| tx_ie | input | 2 | Transmit request enable |
| st_ie | input | 2 | Status request enable |
| st_mask | input | 2x6 | Per-input status change enables |
| rx_char | input | 2 | Character received strobe |
| sc_ovr | input | 2 | Receiver overrun strobe |
| sc_frm | input | 2 | Framing error strobe |
| sc_eof | input | 2 | End of frame strobe |
| sc_par | input | 2 | Parity error strobe |
| tx_empty | input | 2 | Transmit buffer became empty strobe |
| st_in | input | 2x6 | Status input levels |
| cmd_ack_rx | input | 2 | Clear receive request |
| cmd_rst_tx | input | 2 | Clear transmit request |
| cmd_rst_st | input | 2 | Clear status request and unfreeze the snapshot |
| cmd_rearm_rx | input | 2 | Re-arm first-character mode |
| master_ie | input | 1 | Master interrupt enable |
| pend | output | 8 | Pending register |
| irq | output | 1 | Interrupt request |
| irq_id | output | 3 | Highest-priority pending source, 7 when none |
| st_snap | output | 2x6 | Status snapshot for each channel |

## Verification
Every latched bit, and `st_snap`, changes at the clock edge that samples the strobe or the input change. `irq` and `irq_id` follow `pend` and `master_ie` combinationally within the same cycle. The bench changes inputs 1 ns after a rising edge and checks 1 ns after the next rising edge, so each check sees exactly one register update. The timing check for R12 also reads `pend` before that edge. The freeze case for R8 counts two edges: the first one clears the request, and the second one latches the change that was held back.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCH = 2;
  localparam int NSRC = 3 * NCH;
  localparam int IDW = 3;

  typedef enum logic [1:0] {
    RXI_OFF   = 2'b00,
    RXI_FIRST = 2'b01,
    RXI_ALL   = 2'b10,
    RXI_SC    = 2'b11
  } rx_mode_e;

  localparam logic [IDW-1:0] ID_NONE = 3'd7;
endpackage

// File: rtl/stat_watch.sv
module stat_watch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] st_in,
  input  logic [W-1:0] mask,
  input  logic         ie,
  input  logic         clr,
  output logic         pend,
  output logic [W-1:0] snap
);
  logic [W-1:0] snap_q, snap_d;
  logic         pend_q, pend_d;
  logic         seeded_q, seeded_d;
  logic         hit;

  always_comb begin
    hit      = seeded_q && ie && (|((st_in ^ snap_q) & mask));
    seeded_d = 1'b1;
    snap_d   = snap_q;
    pend_d   = pend_q;
    if (!pend_q) snap_d = st_in;
    if (clr) pend_d = 1'b0;
    if (!pend_q && hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q   <= '0;
      pend_q   <= 1'b0;
      seeded_q <= 1'b0;
    end else begin
      snap_q   <= snap_d;
      pend_q   <= pend_d;
      seeded_q <= seeded_d;
    end
  end

  assign pend = pend_q;
  assign snap = snap_q;

  // R8: snapshot frozen while a request is latched
  a_r8_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(snap_q));
  // R7: no status request without the enable
  a_r7_no_set_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |=> !$rose(pend_q));
endmodule

// File: rtl/chan_irq.sv
module chan_irq import irq_pkg::*; #(
  parameter int STW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     rx_mode,
  input  logic           par_sc_en,
  input  logic           tx_ie,
  input  logic           st_ie,
  input  logic [STW-1:0] st_mask,
  input  logic           rx_char,
  input  logic           sc_ovr,
  input  logic           sc_frm,
  input  logic           sc_eof,
  input  logic           sc_par,
  input  logic           tx_empty,
  input  logic [STW-1:0] st_in,
  input  logic           cmd_ack_rx,
  input  logic           cmd_rst_tx,
  input  logic           cmd_rst_st,
  input  logic           cmd_rearm_rx,
  output logic           rx_pend,
  output logic           tx_pend,
  output logic           st_pend,
  output logic [STW-1:0] st_snap
);
  rx_mode_e mode;
  logic     sc_hit, rx_set, tx_set;
  logic     rx_q, rx_d, tx_q, tx_d, arm_q, arm_d;

  always_comb begin
    mode   = rx_mode_e'(rx_mode);
    sc_hit = sc_ovr | sc_frm | sc_eof | (sc_par & par_sc_en);
    unique case (mode)
      RXI_OFF:   rx_set = 1'b0;
      RXI_FIRST: rx_set = (rx_char & arm_q) | sc_hit;
      RXI_ALL:   rx_set = rx_char | sc_hit;
      default:   rx_set = sc_hit;
    endcase
    tx_set = tx_empty & tx_ie;
    arm_d  = arm_q;
    if (mode == RXI_FIRST && rx_char) arm_d = 1'b0;
    if (cmd_rearm_rx) arm_d = 1'b1;
    rx_d = rx_set | (rx_q & ~cmd_ack_rx);
    tx_d = tx_set | (tx_q & ~cmd_rst_tx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
      arm_q <= 1'b1;
    end else begin
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      arm_q <= arm_d;
    end
  end

  stat_watch #(.W(STW)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .st_in (st_in),
    .mask  (st_mask),
    .ie    (st_ie),
    .clr   (cmd_rst_st),
    .pend  (st_pend),
    .snap  (st_snap)
  );

  assign rx_pend = rx_q;
  assign tx_pend = tx_q;

  // R3: receive mode off never latches
  a_r3_rx_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == 2'b00) |=> !$rose(rx_q));
  // R6: transmit request needs its enable
  a_r6_tx_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ie |=> !$rose(tx_q));
  // R6: clear without a new event empties the bit
  a_r6_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rst_tx && !(tx_empty && tx_ie)) |=> !tx_q);
endmodule

// File: rtl/irq_prio.sv
module irq_prio import irq_pkg::*; #(
  parameter int N = NSRC
) (
  input  logic [N-1:0]   req,
  output logic [IDW-1:0] id
);
  always_comb begin
    id = ID_NONE;
    for (int i = 0; i < N; i++) begin
      if (req[i]) id = IDW'(N - 1 - i);
    end
  end
endmodule

// File: rtl/dual_chan_irq.sv
module dual_chan_irq import irq_pkg::*; #(
  parameter int STW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0][1:0]      rx_mode,
  input  logic [NCH-1:0]           par_sc_en,
  input  logic [NCH-1:0]           tx_ie,
  input  logic [NCH-1:0]           st_ie,
  input  logic [NCH-1:0][STW-1:0]  st_mask,
  input  logic [NCH-1:0]           rx_char,
  input  logic [NCH-1:0]           sc_ovr,
  input  logic [NCH-1:0]           sc_frm,
  input  logic [NCH-1:0]           sc_eof,
  input  logic [NCH-1:0]           sc_par,
  input  logic [NCH-1:0]           tx_empty,
  input  logic [NCH-1:0][STW-1:0]  st_in,
  input  logic [NCH-1:0]           cmd_ack_rx,
  input  logic [NCH-1:0]           cmd_rst_tx,
  input  logic [NCH-1:0]           cmd_rst_st,
  input  logic [NCH-1:0]           cmd_rearm_rx,
  input  logic                     master_ie,
  output logic [7:0]               pend,
  output logic                     irq,
  output logic [IDW-1:0]           irq_id,
  output logic [NCH-1:0][STW-1:0]  st_snap
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [NCH-1:0]   rxp, txp, stp;
  logic [NSRC-1:0]  req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_irq #(.STW(STW)) u_ch (
      .clk          (clk),
      .rst_n        (rst_ni),
      .rx_mode      (rx_mode[c]),
      .par_sc_en    (par_sc_en[c]),
      .tx_ie        (tx_ie[c]),
      .st_ie        (st_ie[c]),
      .st_mask      (st_mask[c]),
      .rx_char      (rx_char[c]),
      .sc_ovr       (sc_ovr[c]),
      .sc_frm       (sc_frm[c]),
      .sc_eof       (sc_eof[c]),
      .sc_par       (sc_par[c]),
      .tx_empty     (tx_empty[c]),
      .st_in        (st_in[c]),
      .cmd_ack_rx   (cmd_ack_rx[c]),
      .cmd_rst_tx   (cmd_rst_tx[c]),
      .cmd_rst_st   (cmd_rst_st[c]),
      .cmd_rearm_rx (cmd_rearm_rx[c]),
      .rx_pend      (rxp[c]),
      .tx_pend      (txp[c]),
      .st_pend      (stp[c]),
      .st_snap      (st_snap[c])
    );
    assign req[NSRC-1-3*c -: 3] = {rxp[c], txp[c], stp[c]};
  end

  irq_prio #(.N(NSRC)) u_prio (
    .req (req),
    .id  (irq_id)
  );

  assign pend = {2'b00, req};
  assign irq  = master_ie & (|req);

  // R9: output silent without the master enable
  a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_ni)
    !master_ie |-> !irq);
  // R10: reported source is a set pending bit
  a_r10_id_is_pending: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> pend[3'd5 - irq_id]);
  // R2: top bits never set
  a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    pend[7:6] == 2'b00);
endmodule

// File: tb/tb_dual_chan_irq.sv
module tb_dual_chan_irq;
  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0][1:0] rx_mode;
  logic [1:0]      par_sc_en, tx_ie, st_ie;
  logic [1:0][5:0] st_mask, st_in;
  logic [1:0]      rx_char, sc_ovr, sc_frm, sc_eof, sc_par, tx_empty;
  logic [1:0]      cmd_ack_rx, cmd_rst_tx, cmd_rst_st, cmd_rearm_rx;
  logic            master_ie;
  logic [7:0]      pend;
  logic            irq;
  logic [2:0]      irq_id;
  logic [1:0][5:0] st_snap;
  int              n_chk = 0;
  int              n_bad = 0;
  bit              done = 1'b0;

  always #5 clk = ~clk;

  dual_chan_irq dut (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .par_sc_en(par_sc_en),
    .tx_ie(tx_ie), .st_ie(st_ie), .st_mask(st_mask), .rx_char(rx_char),
    .sc_ovr(sc_ovr), .sc_frm(sc_frm), .sc_eof(sc_eof), .sc_par(sc_par),
    .tx_empty(tx_empty), .st_in(st_in), .cmd_ack_rx(cmd_ack_rx),
    .cmd_rst_tx(cmd_rst_tx), .cmd_rst_st(cmd_rst_st),
    .cmd_rearm_rx(cmd_rearm_rx), .master_ie(master_ie), .pend(pend),
    .irq(irq), .irq_id(irq_id), .st_snap(st_snap)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    rx_char = '0; sc_ovr = '0; sc_frm = '0; sc_eof = '0; sc_par = '0;
    tx_empty = '0; cmd_ack_rx = '0; cmd_rst_tx = '0; cmd_rst_st = '0;
    cmd_rearm_rx = '0;
  endtask

  task automatic ack_rx(input int ch);
    cmd_ack_rx[ch] = 1'b1; step(); clear_strobes();
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 id", irq_id, 7);
  endtask

  task automatic t_rx_every();
    rx_mode[0] = 2'b00;
    rx_char[0] = 1'b1; step(); clear_strobes();
    chk("R3 mode off", pend, 8'h00);
    rx_mode[0] = 2'b10;
    rx_char[0] = 1'b1; #2;
    chk("R12 before edge", pend, 8'h00);
    step(); clear_strobes();
    chk("R2 R3 R12 A rx bit5", pend, 8'h20);
    ack_rx(0);
    chk("R11 ack clears", pend, 8'h00);
    rx_char[0] = 1'b1; step(); clear_strobes();
    chk("R3 second char", pend, 8'h20);
    ack_rx(0);
  endtask

  task automatic t_rx_first();
    rx_mode[0] = 2'b01;
    rx_char[0] = 1'b1; step(); clear_strobes();
    chk("R4 first char", pend, 8'h20);
    ack_rx(0);
    rx_char[0] = 1'b1; step(); clear_strobes();
    chk("R4 later char ignored", pend, 8'h00);
    sc_frm[0] = 1'b1; step(); clear_strobes();
    chk("R4 special still latches", pend, 8'h20);
    ack_rx(0);
    cmd_rearm_rx[0] = 1'b1; step(); clear_strobes();
    rx_char[0] = 1'b1; step(); clear_strobes();
    chk("R4 after rearm", pend, 8'h20);
    ack_rx(0);
  endtask

  task automatic t_rx_special();
    rx_mode[0] = 2'b11;
    rx_char[0] = 1'b1; step(); clear_strobes();
    chk("R5 plain char ignored", pend, 8'h00);
    sc_ovr[0] = 1'b1; step(); clear_strobes();
    chk("R5 overrun", pend, 8'h20);
    ack_rx(0);
    sc_eof[0] = 1'b1; step(); clear_strobes();
    chk("R5 end of frame", pend, 8'h20);
    ack_rx(0);
    par_sc_en[0] = 1'b0;
    sc_par[0] = 1'b1; step(); clear_strobes();
    chk("R5 parity off", pend, 8'h00);
    par_sc_en[0] = 1'b1;
    sc_par[0] = 1'b1; step(); clear_strobes();
    chk("R5 parity on", pend, 8'h20);
    ack_rx(0);
    rx_mode[0] = 2'b00;
  endtask

  task automatic t_tx();
    tx_ie[1] = 1'b0;
    tx_empty[1] = 1'b1; step(); clear_strobes();
    chk("R6 disabled", pend, 8'h00);
    tx_ie[1] = 1'b1;
    tx_empty[1] = 1'b1; step(); clear_strobes();
    chk("R2 R6 B tx bit1", pend, 8'h02);
    cmd_rst_tx[1] = 1'b1; step(); clear_strobes();
    chk("R6 reset tx", pend, 8'h00);
    tx_empty[1] = 1'b1; cmd_rst_tx[1] = 1'b1; step(); clear_strobes();
    chk("R11 set wins tx", pend, 8'h02);
    cmd_rst_tx[1] = 1'b1; step(); clear_strobes();
  endtask

  task automatic t_status();
    st_ie[1] = 1'b1; st_mask[1] = 6'b000010;
    st_in[1][1] = 1'b1; step();
    chk("R2 R7 rise", pend, 8'h01);
    chk("R7 snap", st_snap[1], 6'b000010);
    cmd_rst_st[1] = 1'b1; step(); clear_strobes();
    chk("R7 reset status", pend, 8'h00);
    st_in[1][1] = 1'b0; step();
    chk("R7 fall", pend, 8'h01);
    cmd_rst_st[1] = 1'b1; step(); clear_strobes();
    st_in[1][0] = 1'b1; step(); step();
    chk("R7 masked input", pend, 8'h00);
    chk("R7 snap tracks", st_snap[1], 6'b000001);
  endtask

  task automatic t_freeze();
    st_in[1][1] = 1'b1; step();
    chk("R8 latched", pend, 8'h01);
    st_in[1][1] = 1'b0; step();
    chk("R8 snap frozen", st_snap[1], 6'b000011);
    chk("R8 still one", pend, 8'h01);
    cmd_rst_st[1] = 1'b1; step(); clear_strobes();
    chk("R8 cleared", pend, 8'h00);
    step();
    chk("R8 held change seen", pend, 8'h01);
    cmd_rst_st[1] = 1'b1; step(); clear_strobes();
    step();
    chk("R8 no repeat", pend, 8'h00);
  endtask

  task automatic t_master_prio();
    master_ie = 1'b0; tx_ie[0] = 1'b1;
    tx_empty[0] = 1'b1; step(); clear_strobes();
    chk("R9 latched without master", pend, 8'h10);
    chk("R9 irq off", irq, 0);
    master_ie = 1'b1; #1;
    chk("R9 irq on", irq, 1);
    chk("R10 id A tx", irq_id, 1);
    rx_mode[1] = 2'b10;
    rx_char[1] = 1'b1; step(); clear_strobes();
    chk("R10 two pending", pend, 8'h14);
    chk("R10 A tx first", irq_id, 1);
    cmd_rst_tx[0] = 1'b1; step(); clear_strobes();
    chk("R10 B rx next", irq_id, 3);
    rx_mode[0] = 2'b10;
    rx_char[0] = 1'b1; cmd_ack_rx[0] = 1'b1; step(); clear_strobes();
    chk("R11 set wins rx", pend, 8'h24);
    chk("R10 A rx top", irq_id, 0);
    ack_rx(0); ack_rx(1);
    chk("R10 none", irq_id, 7);
    chk("R9 none irq", irq, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_mode = '0; par_sc_en = '0; tx_ie = '0; st_ie = '0; st_mask = '0;
    st_in = '0; master_ie = 1'b0;
    clear_strobes();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_rx_every();
    t_rx_first();
    t_rx_special();
    t_tx();
    t_status();
    t_freeze();
    t_master_prio();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule